// File: doc/BRIEF.md
# Fetch Line Termination Controller

This block makes the per-instruction decision for one hardware thread as it fetches from a single cache line within one fetch cycle. For each instruction the fetch pipeline presents, it works out three things. The first is whether fetch goes on in the same line. The second is whether the line is finished but the thread may start another line in this cycle. The third is whether the thread must stop fetching until the next cycle. It also forms the predicted next PC, the word-aligned memory request address and a flag for a taken prediction that arrived with no target. It keeps the running instruction and branch counts for the cycle and the thread's speculation depth.

The fetch sequencer marks the first instruction of a cycle with `cyc_start` and the first instruction of a line with `line_start`. Every result appears one clock after its instruction is presented. Software prefetch instructions can be filtered out when the filtering enable is set. A filtered prefetch still advances the PC but uses none of the cycle's fetch budget. The branch predictor, decode and functional execution sit outside the block. They supply the predictor's target and the resolved next PC.

Top module: `fetch_line_term`

## Requirements
- R1: A line holds BLOCK_BYTES/INST_BYTES instructions. An instruction whose PC slot bits [4:2] equal 7 (defaults) closes the line with `res_action` = 1 (next line), unless a stop condition applies.
- R2: A control instruction that is predicted taken and comes with a target sets `next_pc` to that target and `res_action` to 1 (next line).
- R3: A fault or a full fetch queue on a kept instruction gives `res_action` = 2 (stop thread). A faulting instruction is still counted as fetched.
- R4: When the cycle's kept-instruction count reaches MAX_INSTS (8), or its branch count reaches MAX_BRANCHES (2), `res_action` = 2.
- R5: A stop-thread condition takes priority over a line end or a taken redirect on the same instruction.
- R6: An instruction that is not a control instruction, or is predicted not taken, gets `next_pc` = PC + INST_BYTES. With no terminating condition, `res_action` = 0 (continue).
- R7: A taken prediction with no target raises `btb_miss` and gets `next_pc` = PC + INST_BYTES. It does not end the line by itself.
- R8: When `pf_squash_en` is 1, a prefetch instruction gives `res_kept` = 0 and `next_pc` = PC + INST_BYTES, and leaves the instruction and line counts unchanged. When `pf_squash_en` is 0, the prefetch is counted like any other instruction.
- R9: `req_addr` is the instruction PC with bits [1:0] cleared.
- R10: A kept, non-faulting instruction whose `next_pc` differs from `resolved_pc` raises `recover` and adds one to `spec_depth`. The depth saturates at 2**SPEC_W-1 (7), and does not change on any other result.
- R11: `inst_cnt` and `br_cnt` accumulate across lines and are cleared by `cyc_start`. `line_cnt` is cleared by `line_start`. Each counts the presented instruction when it is kept.
- R12: After reset, every output is 0. Each result appears on the outputs one clock after its instruction, and `res_valid` is 0 in the cycles that follow a clock with no instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_start | input | 1 | First instruction of a fetch cycle; clears the per-cycle counts |
| line_start | input | 1 | First instruction of a line; clears the line count |
| inst_valid | input | 1 | An instruction is presented |
| inst_pc | input | AW | Instruction address |
| is_control | input | 1 | Instruction changes control flow |
| pred_taken | input | 1 | Predictor says taken |
| pred_has_tgt | input | 1 | Predictor supplied a target |
| pred_tgt | input | AW | Predicted target |
| is_prefetch | input | 1 | Software prefetch instruction |
| pf_squash_en | input | 1 | Filter out prefetch instructions |
| fetch_fault | input | 1 | Fetch or execution fault on this instruction |
| ifq_full | input | 1 | Fetch queue full after this instruction |
| resolved_pc | input | AW | Actual next PC from execution |
| res_valid | output | 1 | A result is present |
| res_action | output | 2 | 0 continue, 1 next line, 2 stop thread |
| res_kept | output | 1 | Instruction was kept (not filtered) |
| next_pc | output | AW | Predicted next PC |
| btb_miss | output | 1 | Taken prediction with no target |
| recover | output | 1 | Instruction is a recovery point |
| req_addr | output | AW | Word-aligned memory request address |
| line_cnt | output | LCW | Kept instructions in this line |
| inst_cnt | output | CW | Kept instructions in this cycle |
| br_cnt | output | BW | Kept branches in this cycle |
| spec_depth | output | SPEC_W | Speculation depth of the thread |

## Verification
On every cycle, the assertions check four properties. A fault always yields a stop-thread result. A result that brings the cycle count to its limit is a stop. A filtered prefetch never moves the instruction count. The speculation depth moves only with a recovery flag and then by exactly one. The bench's scenarios are needed to show the next-PC choices, the line-end slot and the priority of stops over line ends. They also cover how counts carry across lines and reset at a cycle start, and the saturation of the speculation depth.

// File: rtl/fetch_term_pkg.sv
package fetch_term_pkg;
    typedef enum logic [1:0] {
        ACT_CONTINUE    = 2'd0,
        ACT_NEXT_LINE   = 2'd1,
        ACT_STOP_THREAD = 2'd2
    } act_e;
endpackage

// File: rtl/ft_pc_predict.sv
module ft_pc_predict #(
    parameter int AW          = 32,
    parameter int INST_BYTES  = 4,
    parameter int BLOCK_BYTES = 32
) (
    input  logic [AW-1:0] pc,
    input  logic          is_control,
    input  logic          pred_taken,
    input  logic          pred_has_tgt,
    input  logic [AW-1:0] pred_tgt,
    output logic [AW-1:0] next_pc,
    output logic          btb_miss,
    output logic          redirect,
    output logic          line_end,
    output logic [AW-1:0] req_addr
);
    localparam int IPL    = BLOCK_BYTES / INST_BYTES;
    localparam int OFS_LO = $clog2(INST_BYTES);
    localparam int SLOT_W = $clog2(IPL);

    logic [AW-1:0] seq_pc;

    always_comb begin
        seq_pc   = pc + AW'(INST_BYTES);
        redirect = is_control && pred_taken && pred_has_tgt;
        btb_miss = is_control && pred_taken && !pred_has_tgt;
        next_pc  = redirect ? pred_tgt : seq_pc;
        line_end = (pc[OFS_LO +: SLOT_W] == SLOT_W'(IPL - 1));
        req_addr = {pc[AW-1:2], 2'b00};
    end
endmodule

// File: rtl/ft_stop_decide.sv
module ft_stop_decide
    import fetch_term_pkg::*;
#(
    parameter int CW           = 4,
    parameter int BW           = 2,
    parameter int MAX_INSTS    = 8,
    parameter int MAX_BRANCHES = 2
) (
    input  logic          kept,
    input  logic          fault,
    input  logic          ifq_full,
    input  logic [CW-1:0] inst_cnt_new,
    input  logic [BW-1:0] br_cnt_new,
    input  logic          line_end,
    input  logic          redirect,
    output act_e          action
);
    logic stop_thread, stop_line;

    always_comb begin
        stop_thread = kept && (fault || ifq_full ||
                      (inst_cnt_new >= CW'(MAX_INSTS)) ||
                      (br_cnt_new   >= BW'(MAX_BRANCHES)));
        stop_line   = line_end || (kept && redirect);
        if (stop_thread)    action = ACT_STOP_THREAD;
        else if (stop_line) action = ACT_NEXT_LINE;
        else                action = ACT_CONTINUE;
    end
endmodule

// File: rtl/fetch_line_term.sv
module fetch_line_term
    import fetch_term_pkg::*;
#(
    parameter int AW           = 32,
    parameter int INST_BYTES   = 4,
    parameter int BLOCK_BYTES  = 32,
    parameter int MAX_INSTS    = 8,
    parameter int MAX_BRANCHES = 2,
    parameter int SPEC_W       = 3,
    localparam int IPL         = BLOCK_BYTES / INST_BYTES,
    localparam int CW          = $clog2(MAX_INSTS + 1),
    localparam int BW          = $clog2(MAX_BRANCHES + 1),
    localparam int LCW         = $clog2(IPL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              line_start,
    input  logic              inst_valid,
    input  logic [AW-1:0]     inst_pc,
    input  logic              is_control,
    input  logic              pred_taken,
    input  logic              pred_has_tgt,
    input  logic [AW-1:0]     pred_tgt,
    input  logic              is_prefetch,
    input  logic              pf_squash_en,
    input  logic              fetch_fault,
    input  logic              ifq_full,
    input  logic [AW-1:0]     resolved_pc,
    output logic              res_valid,
    output logic [1:0]        res_action,
    output logic              res_kept,
    output logic [AW-1:0]     next_pc,
    output logic              btb_miss,
    output logic              recover,
    output logic [AW-1:0]     req_addr,
    output logic [LCW-1:0]    line_cnt,
    output logic [CW-1:0]     inst_cnt,
    output logic [BW-1:0]     br_cnt,
    output logic [SPEC_W-1:0] spec_depth
);
    localparam logic [SPEC_W-1:0] SPEC_MAX = {SPEC_W{1'b1}};

    typedef struct packed {
        logic              valid;
        act_e              act;
        logic              kept;
        logic [AW-1:0]     npc;
        logic              btb;
        logic              rec;
        logic [AW-1:0]     req;
        logic [LCW-1:0]    lcnt;
        logic [CW-1:0]     icnt;
        logic [BW-1:0]     bcnt;
        logic [SPEC_W-1:0] spec;
    } state_t;

    state_t st_d, st_q;

    logic          kept;
    logic [AW-1:0] pr_npc, pr_req;
    logic          pr_btb, pr_redirect, pr_line_end;
    logic [CW-1:0] icnt_base, icnt_new;
    logic [BW-1:0] bcnt_base, bcnt_new;
    logic [LCW-1:0] lcnt_base, lcnt_new;
    act_e          action;

    assign kept = inst_valid && !(pf_squash_en && is_prefetch);

    ft_pc_predict #(
        .AW(AW), .INST_BYTES(INST_BYTES), .BLOCK_BYTES(BLOCK_BYTES)
    ) u_pc_predict (
        .pc           (inst_pc),
        .is_control   (is_control && kept),
        .pred_taken   (pred_taken),
        .pred_has_tgt (pred_has_tgt),
        .pred_tgt     (pred_tgt),
        .next_pc      (pr_npc),
        .btb_miss     (pr_btb),
        .redirect     (pr_redirect),
        .line_end     (pr_line_end),
        .req_addr     (pr_req)
    );

    // Running counts: cleared at their start markers, saturate at limits
    always_comb begin
        icnt_base = cyc_start  ? '0 : st_q.icnt;
        bcnt_base = cyc_start  ? '0 : st_q.bcnt;
        lcnt_base = line_start ? '0 : st_q.lcnt;
        icnt_new  = icnt_base;
        bcnt_new  = bcnt_base;
        lcnt_new  = lcnt_base;
        if (kept && icnt_base != CW'(MAX_INSTS))
            icnt_new = icnt_base + CW'(1);
        if (kept && is_control && bcnt_base != BW'(MAX_BRANCHES))
            bcnt_new = bcnt_base + BW'(1);
        if (kept && lcnt_base != LCW'(IPL))
            lcnt_new = lcnt_base + LCW'(1);
    end

    ft_stop_decide #(
        .CW(CW), .BW(BW), .MAX_INSTS(MAX_INSTS), .MAX_BRANCHES(MAX_BRANCHES)
    ) u_stop_decide (
        .kept         (kept),
        .fault        (fetch_fault),
        .ifq_full     (ifq_full),
        .inst_cnt_new (icnt_new),
        .br_cnt_new   (bcnt_new),
        .line_end     (inst_valid && pr_line_end),
        .redirect     (pr_redirect),
        .action       (action)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = inst_valid;
        st_d.kept  = kept;
        st_d.act   = ACT_CONTINUE;
        st_d.rec   = 1'b0;
        st_d.btb   = 1'b0;
        st_d.icnt  = icnt_new;
        st_d.bcnt  = bcnt_new;
        st_d.lcnt  = lcnt_new;
        if (inst_valid) begin
            st_d.act = action;
            st_d.npc = pr_npc;
            st_d.req = pr_req;
            st_d.btb = pr_btb;
            st_d.rec = kept && !fetch_fault && (pr_npc != resolved_pc);
            if (st_d.rec && st_q.spec != SPEC_MAX)
                st_d.spec = st_q.spec + SPEC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid  = st_q.valid;
    assign res_action = st_q.act;
    assign res_kept   = st_q.kept;
    assign next_pc    = st_q.npc;
    assign btb_miss   = st_q.btb;
    assign recover    = st_q.rec;
    assign req_addr   = st_q.req;
    assign line_cnt   = st_q.lcnt;
    assign inst_cnt   = st_q.icnt;
    assign br_cnt     = st_q.bcnt;
    assign spec_depth = st_q.spec;

    // R3: a kept faulting instruction always ends the thread's cycle
    assert_fault_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && fetch_fault && !(pf_squash_en && is_prefetch))
        |=> (res_valid && res_action == ACT_STOP_THREAD));

    // R4: a kept result at the cycle instruction limit is a stop
    assert_limit_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kept && inst_cnt == CW'(MAX_INSTS))
        |-> (res_action == ACT_STOP_THREAD));

    // R8: a filtered prefetch consumes no fetch budget
    assert_pf_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && pf_squash_en && is_prefetch && !cyc_start)
        |=> (!res_kept && inst_cnt == $past(inst_cnt)));

    // R10: speculation depth moves only with a recovery point, by one
    assert_spec_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (recover && $past(spec_depth) != SPEC_MAX)
        |-> (spec_depth == $past(spec_depth) + SPEC_W'(1)));

    assert_spec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !recover |-> $stable(spec_depth));

    // R11: branch count never falls within one cycle
    assert_br_mono_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> (br_cnt >= $past(br_cnt)));
endmodule

// File: tb/fetch_line_term_bench.sv
`timescale 1ns/1ps
module fetch_line_term_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start, line_start, inst_valid;
    logic [31:0] inst_pc, pred_tgt, resolved_pc;
    logic        is_control, pred_taken, pred_has_tgt, is_prefetch;
    logic        pf_squash_en, fetch_fault, ifq_full;
    logic        res_valid, res_kept, btb_miss, recover;
    logic [1:0]  res_action;
    logic [31:0] next_pc, req_addr;
    logic [3:0]  line_cnt, inst_cnt;
    logic [1:0]  br_cnt;
    logic [2:0]  spec_depth;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fetch_line_term u_fetch_line_term (
        .clk, .rst_n, .cyc_start, .line_start, .inst_valid, .inst_pc,
        .is_control, .pred_taken, .pred_has_tgt, .pred_tgt, .is_prefetch,
        .pf_squash_en, .fetch_fault, .ifq_full, .resolved_pc,
        .res_valid, .res_action, .res_kept, .next_pc, .btb_miss, .recover,
        .req_addr, .line_cnt, .inst_cnt, .br_cnt, .spec_depth
    );

    typedef struct packed {
        logic        cyc, line;
        logic [31:0] pc;
        logic        ctl, tk, ht;
        logic [31:0] tgt;
        logic        pf, sq, flt, full;
        logic [31:0] rpc;
        logic [1:0]  act;
        logic [31:0] npc;
        logic        btb, rec, kept;
        logic [3:0]  icnt;
        logic [1:0]  bcnt;
        logic [3:0]  lcnt;
        logic [2:0]  spec;
    } vec_t;

    // order: cyc line pc ctl tk ht tgt pf sq flt full rpc | act npc btb rec kept icnt bcnt lcnt spec
    localparam vec_t VECS [12] = '{
        '{1,1,32'h100,0,0,0,32'h0  ,0,0,0,0,32'h104, 2'd0,32'h104,0,0,1,4'd1,2'd0,4'd1,3'd0}, // R6
        '{0,0,32'h104,0,0,0,32'h0  ,0,0,0,0,32'h108, 2'd0,32'h108,0,0,1,4'd2,2'd0,4'd2,3'd0}, // R11
        '{0,0,32'h108,1,1,1,32'h21C,0,0,0,0,32'h21C, 2'd1,32'h21C,0,0,1,4'd3,2'd1,4'd3,3'd0}, // R2
        '{0,1,32'h21C,0,0,0,32'h0  ,0,0,0,0,32'h220, 2'd1,32'h220,0,0,1,4'd4,2'd1,4'd1,3'd0}, // R1
        '{0,1,32'h220,0,0,0,32'h0  ,1,1,0,0,32'h224, 2'd0,32'h224,0,0,0,4'd4,2'd1,4'd0,3'd0}, // R8
        '{0,0,32'h224,0,0,0,32'h0  ,1,0,0,0,32'h228, 2'd0,32'h228,0,0,1,4'd5,2'd1,4'd1,3'd0}, // R8
        '{0,0,32'h228,1,1,0,32'h0  ,0,0,0,0,32'h22C, 2'd2,32'h22C,1,0,1,4'd6,2'd2,4'd2,3'd0}, // R4
        '{1,1,32'h300,1,1,0,32'h0  ,0,0,0,0,32'h304, 2'd0,32'h304,1,0,1,4'd1,2'd1,4'd1,3'd0}, // R7
        '{0,0,32'h304,0,0,0,32'h0  ,0,0,0,0,32'h400, 2'd0,32'h308,0,1,1,4'd2,2'd1,4'd2,3'd1}, // R10
        '{0,0,32'h308,0,0,0,32'h0  ,0,0,0,1,32'h30C, 2'd2,32'h30C,0,0,1,4'd3,2'd1,4'd3,3'd1}, // R3
        '{1,1,32'h31C,0,0,0,32'h0  ,0,0,1,0,32'h320, 2'd2,32'h320,0,0,1,4'd1,2'd0,4'd1,3'd1}, // R5
        '{1,1,32'h402,0,0,0,32'h0  ,0,0,0,0,32'h406, 2'd0,32'h406,0,0,1,4'd1,2'd0,4'd1,3'd1}  // R9
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cyc_start = v.cyc; line_start = v.line; inst_valid = 1'b1;
        inst_pc = v.pc; is_control = v.ctl; pred_taken = v.tk;
        pred_has_tgt = v.ht; pred_tgt = v.tgt; is_prefetch = v.pf;
        pf_squash_en = v.sq; fetch_fault = v.flt; ifq_full = v.full;
        resolved_pc = v.rpc;
    endtask

    task automatic idle();
        inst_valid = 1'b0; cyc_start = 1'b0; line_start = 1'b0;
    endtask

    // apply at a falling edge, compare at the next falling edge
    task automatic run(input vec_t v, input string tag);
        drive(v);
        @(negedge clk);
        chk(res_valid == 1'b1,   tag, "res_valid",  res_valid,  1);
        chk(res_action == v.act, tag, "res_action", res_action, v.act);
        chk(next_pc == v.npc,    tag, "next_pc",    next_pc,    v.npc);
        chk(btb_miss == v.btb,   tag, "btb_miss",   btb_miss,   v.btb);
        chk(recover == v.rec,    tag, "recover",    recover,    v.rec);
        chk(res_kept == v.kept,  tag, "res_kept",   res_kept,   v.kept);
        chk(inst_cnt == v.icnt,  tag, "inst_cnt",   inst_cnt,   v.icnt);
        chk(br_cnt == v.bcnt,    tag, "br_cnt",     br_cnt,     v.bcnt);
        chk(line_cnt == v.lcnt,  tag, "line_cnt",   line_cnt,   v.lcnt);
        chk(spec_depth == v.spec, tag, "spec_depth", spec_depth, v.spec);
        chk(req_addr == {v.pc[31:2], 2'b00}, "R9", "req_addr", req_addr, {v.pc[31:2], 2'b00});
    endtask

    initial begin
        vec_t v;
        idle();
        inst_pc = '0; pred_tgt = '0; resolved_pc = '0; is_control = 0;
        pred_taken = 0; pred_has_tgt = 0; is_prefetch = 0; pf_squash_en = 0;
        fetch_fault = 0; ifq_full = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(res_valid == 0 && res_action == 0 && inst_cnt == 0 && br_cnt == 0
            && line_cnt == 0 && spec_depth == 0 && next_pc == 0 && recover == 0,
            "R12", "reset outputs", {res_valid, res_action, inst_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 12; i++) run(VECS[i], $sformatf("vec%0d", i));

        // R12: idle cycle gives no result, depth held
        idle();
        @(negedge clk);
        chk(res_valid == 0, "R12", "idle res_valid", res_valid, 0);
        chk(spec_depth == 3'd1, "R10", "idle spec hold", spec_depth, 1);

        // R4 R5: eighth instruction hits the limit on the line-end slot
        for (int k = 0; k < 8; k++) begin
            v = '0;
            v.cyc = (k == 0); v.line = (k == 0);
            v.pc = 32'h500 + 32'(4 * k); v.rpc = v.pc + 32'd4;
            drive(v);
            @(negedge clk);
            if (k == 6) chk(res_action == 2'd0 && inst_cnt == 4'd7, "R4",
                            "seventh continues", {res_action, inst_cnt}, {2'd0, 4'd7});
            if (k == 7) begin
                chk(res_action == 2'd2, "R5", "limit over line end", res_action, 2);
                chk(inst_cnt == 4'd8 && line_cnt == 4'd8, "R4", "counts at limit",
                    {inst_cnt, line_cnt}, {4'd8, 4'd8});
            end
        end

        // R10: depth saturates at 7
        for (int k = 0; k < 8; k++) begin
            v = '0;
            v.cyc = 1; v.line = 1;
            v.pc = 32'h600; v.rpc = 32'h900;
            drive(v);
            @(negedge clk);
        end
        chk(recover == 1'b1, "R10", "recover flag", recover, 1);
        chk(spec_depth == 3'd7, "R10", "depth saturates", spec_depth, 7);

        // R11: cycle start alone clears per-cycle counts
        idle();
        cyc_start = 1'b1; line_start = 1'b1;
        @(negedge clk);
        chk(inst_cnt == 0 && br_cnt == 0 && line_cnt == 0, "R11", "cleared counts",
            {inst_cnt, br_cnt, line_cnt}, 0);
        idle();
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule